// File: doc/BRIEF.md
# Operation-Selected Accumulating Arithmetic Unit

This block is a small unsigned datapath that carries out one of four operations in every clock cycle. A 2-bit operation code picks the operation. Two operand inputs feed it, and one result output leaves it. An internal accumulator register keeps a running total from one cycle to the next. All arithmetic wraps modulo 2^WIDTH. WIDTH defaults to 8 bits.

Sum and difference are purely combinational. They leave the accumulator alone. The accumulate operation adds the first operand to the stored total. It shows the new total on the result output in the same cycle, and stores that total at the next clock edge. The clear operation empties the accumulator and forces the result to zero. A synchronous reset has the same effect on the accumulator as clear. A parameter chooses how subtraction is built: either a plain subtractor beside the adder, or a single adder with an inverted operand and a carry-in.

Top module: `acc_arith_unit`

## Requirements
- R1: With op_sel = 2'b00, result equals (opnd_a + opnd_b) mod 2^WIDTH in the same cycle, and the accumulator keeps its value across the edge.
- R2: With op_sel = 2'b01, result equals (opnd_a - opnd_b) mod 2^WIDTH in the same cycle, and the accumulator keeps its value across the edge.
- R3: With op_sel = 2'b10, result equals (acc + opnd_a) mod 2^WIDTH in the same cycle, and the accumulator holds that value after the next rising edge.
- R4: With op_sel = 2'b11, result is zero in that cycle, and the accumulator is zero after the next rising edge.
- R5: The accumulator is zero after any rising edge at which rst is high, whatever op_sel is. During reset, result still follows op_sel.
- R6: Consecutive accumulate cycles sum the opnd_a values modulo 2^WIDTH, including across wrap-around.
- R7: result never carries an unknown value while op_sel, opnd_a and opnd_b are known.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the accumulator |
| op_sel | input | 2 | Operation: 00 sum, 01 difference, 10 accumulate, 11 clear |
| opnd_a | input | WIDTH | First unsigned operand; the addend when accumulating |
| opnd_b | input | WIDTH | Second unsigned operand; ignored by accumulate and clear |
| result | output | WIDTH | Combinational result of the selected operation |

## Verification
Every result of this block is due in the same cycle as its stimulus. The one exception is the accumulator's new value, which can only be seen in the following cycle, through an accumulate with a zero addend or through later sums. The bench changes inputs on the falling edge and samples result 1 ns later, well before the next rising edge. Its reference accumulator is updated only after that rising edge. Sum and difference are swept over all first operands against a strided set of second operands. Long runs of accumulates check wrap-around, and add, subtract and clear cycles are mixed between them.

// File: rtl/acc_arith_pkg.sv
package acc_arith_pkg;

   typedef enum logic [1:0] {
      OP_SUM   = 2'b00,
      OP_DIFF  = 2'b01,
      OP_ACCUM = 2'b10,
      OP_CLEAR = 2'b11
   } op_e;

   typedef struct packed {
      logic use_acc;    // left operand from accumulator, right from opnd_a
      logic subtract;   // adder forms lhs - rhs
      logic load_acc;   // accumulator captures adder output
      logic clear_acc;  // accumulator captures zero
      logic zero_out;   // result forced to zero
   } ctl_t;

endpackage

// File: rtl/acc_arith_decode.sv
module acc_arith_decode
   import acc_arith_pkg::*;
(
   input  logic [1:0] op_sel,
   output ctl_t       ctl
);

   always_comb begin
      ctl = '0;
      unique case (op_e'(op_sel))
         OP_SUM:   ctl.subtract  = 1'b0;
         OP_DIFF:  ctl.subtract  = 1'b1;
         OP_ACCUM: begin
            ctl.use_acc  = 1'b1;
            ctl.load_acc = 1'b1;
         end
         OP_CLEAR: begin
            ctl.clear_acc = 1'b1;
            ctl.zero_out  = 1'b1;
         end
         default:  ctl = '0;
      endcase
   end

   // exactly one accumulator action or none, never both
   always_comb begin
      a_r4_decode_excl: assert (!(ctl.load_acc && ctl.clear_acc))
         else $error("decode drives load and clear together");
   end

endmodule

// File: rtl/acc_arith_addsub.sv
module acc_arith_addsub #(
   parameter int WIDTH        = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   input  logic             subtract,
   output logic [WIDTH-1:0] sum
);

   if (WIDTH < 1) begin : g_bad_width
      $error("acc_arith_addsub: WIDTH must be at least 1");
   end

   if (SHARED_ADDER) begin : g_shared
      logic [WIDTH-1:0] rhs_eff;
      logic [WIDTH-1:0] cin_ext;
      always_comb begin
         rhs_eff = rhs ^ {WIDTH{subtract}};
         cin_ext = {{(WIDTH-1){1'b0}}, subtract};
         sum     = lhs + rhs_eff + cin_ext;
      end
   end else begin : g_split
      logic [WIDTH-1:0] plus_v;
      logic [WIDTH-1:0] minus_v;
      always_comb begin
         plus_v  = lhs + rhs;
         minus_v = lhs - rhs;
         sum     = subtract ? minus_v : plus_v;
      end
   end

endmodule

// File: rtl/acc_arith_accreg.sv
module acc_arith_accreg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             clear,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] acc
);

   if (WIDTH < 1) begin : g_bad_width
      $error("acc_arith_accreg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst || clear)
         acc <= '0;
      else if (load)
         acc <= din;
   end

   a_r5_reset_zero: assert property (@(posedge clk) rst |=> acc == '0)
      else $error("accumulator not zero after reset");

   a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
      clear |=> acc == '0)
      else $error("accumulator not zero after clear");

   a_r1_hold: assert property (@(posedge clk) disable iff (rst)
      (!load && !clear) |=> $stable(acc))
      else $error("accumulator changed without load or clear");

endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
   import acc_arith_pkg::*;
#(
   parameter int WIDTH        = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       op_sel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] result
);

   localparam logic [WIDTH-1:0] ZERO_W = '0;

   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("acc_arith_unit: WIDTH must lie in 1..64");
   end

   ctl_t             ctl;
   logic [WIDTH-1:0] acc_q;
   logic [WIDTH-1:0] lhs;
   logic [WIDTH-1:0] rhs;
   logic [WIDTH-1:0] sum;

   acc_arith_decode u_decode (
      .op_sel (op_sel),
      .ctl    (ctl)
   );

   always_comb begin
      lhs = ctl.use_acc ? acc_q  : opnd_a;
      rhs = ctl.use_acc ? opnd_a : opnd_b;
   end

   acc_arith_addsub #(
      .WIDTH        (WIDTH),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_addsub (
      .lhs      (lhs),
      .rhs      (rhs),
      .subtract (ctl.subtract),
      .sum      (sum)
   );

   acc_arith_accreg #(
      .WIDTH (WIDTH)
   ) u_accreg (
      .clk   (clk),
      .rst   (rst),
      .load  (ctl.load_acc),
      .clear (ctl.clear_acc),
      .din   (sum),
      .acc   (acc_q)
   );

   assign result = ctl.zero_out ? ZERO_W : sum;

   a_r4_out_zero: assert property (@(posedge clk) disable iff (rst)
      (op_sel == 2'b11) |-> result == ZERO_W)
      else $error("clear did not zero the result");

   a_r3_acc_tracks: assert property (@(posedge clk) disable iff (rst)
      (op_sel == 2'b10) |=> acc_q == $past(result))
      else $error("accumulator does not hold the shown total");

   a_r7_known: assert property (@(posedge clk)
      !$isunknown({op_sel, opnd_a, opnd_b}) |-> !$isunknown(result))
      else $error("result unknown");

endmodule

// File: tb/test_acc_arith_unit.sv
module test_acc_arith_unit;

   localparam int W = 8;
   localparam int M = 1 << W;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [1:0]   op_sel = 2'b00;
   logic [W-1:0] opnd_a = '0;
   logic [W-1:0] opnd_b = '0;
   logic [W-1:0] result;

   int checks = 0;
   int errors = 0;
   int model_acc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   acc_arith_unit #(.WIDTH(W)) i_acc_arith_unit (
      .clk    (clk),
      .rst    (rst),
      .op_sel (op_sel),
      .opnd_a (opnd_a),
      .opnd_b (opnd_b),
      .result (result)
   );

   task automatic check(input string req, input int exp);
      checks++;
      if ($isunknown(result)) begin
         errors++;
         $display("FAIL R7 (%s) result unknown: actual %h expected %0d", req, result, exp);
      end else if (int'(result) != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, result, exp);
      end
   endtask

   // drive on falling edge, sample 1 ns later, update model after rising edge
   task automatic step(input logic r, input logic [1:0] op, input int a, input int b,
                       input string req);
      int exp;
      @(negedge clk);
      rst = r; op_sel = op; opnd_a = W'(a); opnd_b = W'(b);
      #1;
      case (op)
         2'b00:   exp = (a + b) % M;
         2'b01:   exp = (a - b + M) % M;
         2'b10:   exp = (model_acc + a) % M;
         default: exp = 0;
      endcase
      check(req, exp);
      @(posedge clk);
      if (r || op == 2'b11) model_acc = 0;
      else if (op == 2'b10) model_acc = exp;
   endtask

   initial begin
      #400000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      step(1'b1, 2'b00, 0, 0, "R5");
      step(1'b1, 2'b10, 77, 0, "R5");
      // reset state: accumulate zero shows stored value 0
      step(1'b0, 2'b10, 0, 0, "R5");

      // R6: long accumulate run with wrap
      for (int i = 0; i < 300; i++)
         step(1'b0, 2'b10, (i * 37 + 11) % M, i, "R6");
      step(1'b0, 2'b10, 255, 0, "R3");
      step(1'b0, 2'b10, 1, 0, "R3");

      // R1 / R2 sweeps, accumulator must hold
      for (int a = 0; a < M; a++)
         for (int b = 0; b < M; b += 5) begin
            step(1'b0, 2'b00, a, b, "R1");
            step(1'b0, 2'b01, a, b, "R2");
         end
      step(1'b0, 2'b01, 0, 255, "R2");
      step(1'b0, 2'b00, 255, 255, "R1");
      step(1'b0, 2'b10, 0, 99, "R1");   // shows held acc

      // R4 clear, opnd_b has no effect
      step(1'b0, 2'b10, 200, 0, "R3");
      step(1'b0, 2'b11, 123, 45, "R4");
      step(1'b0, 2'b10, 0, 0, "R4");
      step(1'b0, 2'b10, 250, 0, "R3");
      step(1'b0, 2'b10, 10, 0, "R6");

      // R5 reset mid-stream while accumulate selected
      step(1'b1, 2'b10, 9, 0, "R5");
      step(1'b0, 2'b10, 0, 0, "R5");

      // mixed
      for (int i = 0; i < 200; i++)
         step(1'b0, 2'(i % 4), (i * 53) % M, (i * 29) % M, "R7");
      step(1'b0, 2'b10, 0, 0, "R6");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule